// File: doc/BRIEF.md
# Sticky Fault Status and Alert Controller

This block gathers out-of-limit indications from a set of monitored channels (temperatures, supply voltages, a fan and two diode-fault detectors) into two 8-bit status registers. Each status bit latches when its channel's exceed input is seen high. A bit is released only when the fault has gone away and software reads the register that holds it. A read made while the fault is still present leaves the bit set, with no gap. Two 8-bit mask registers decide which latched bits may pull a shared active-low alert output. Masks affect only that output and never the status bits.

The first status register carries a summary flag in its top bit. That flag is high whenever any bit of the second register is set, so one read tells software which register to service. A mask bit in the first mask register silences every source in the second register at once. One input position of the second register is shared: a mode input chooses whether it records a fan failure, the overtemperature input or a general-purpose event. The overtemperature input is also passed to a separate, non-latching flag output.

Software reaches the registers through a simple synchronous port with address, write strobe, read strobe and data. Read data is registered and holds until the next read.

Top module: `alert_status_ctrl`

## Requirements
- R1: After reset both status registers and both mask registers are 0, reg_rdata_o is 0, alert_n_o is 1 and ovt_flag_o is 0.
- R2: A channel whose exceed input is 1 at a rising clock edge has its status bit at 1 after that edge. Status register 1 bits 6..0 follow lim1_i[6..0], and status register 2 bits 7..0 follow lim2_i[7..0] (bit 5 subject to R9). Register addresses are 0 for status 1, 1 for status 2, 2 for mask 1 and 3 for mask 2.
- R3: A read (reg_rd_i=1) returns the value before the edge on reg_rdata_o after that edge. At that edge it clears exactly those bits of the addressed status register whose exceed input is 0. A bit whose input is still 1 stays 1. Status bits never clear without a read of their register.
- R4: Bit 7 of status register 1, as read, is the OR of all bits of status register 2. Reading status register 1 never clears status register 2.
- R5: alert_n_o is 0 exactly when some status-1 bit i (0..6) is set with mask-1 bit i at 0, or some status-2 bit j is set with mask-2 bit j at 0 and mask-1 bit 7 at 0. It reflects register state right after each edge.
- R6: Mask settings have no effect on how status bits set or clear.
- R7: Writes to addresses 0 and 1 are ignored. A write to address 2 or 3 stores reg_wdata_i, which later reads return unchanged.
- R8: ovt_flag_o equals ovt_i from the previous rising edge. It never latches and needs no read.
- R9: The source of status-2 bit 5 depends on pin_mode_i: 0 or 3 selects lim2_i[5], 1 selects ovt_i and 2 selects gpio_evt_i. The unselected inputs have no effect.
- R10: If a mask bit is cleared after its status bit has been released, alert_n_o stays 1. A later fault on that source drives it to 0 again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| lim1_i | input | 7 | Exceed inputs for status register 1 bits 6..0 |
| lim2_i | input | 8 | Exceed inputs for status register 2 (bit 5 is the fan) |
| ovt_i | input | 1 | Live overtemperature condition |
| gpio_evt_i | input | 1 | General-purpose event for the shared bit |
| pin_mode_i | input | 2 | Selects the source of status-2 bit 5 |
| reg_addr_i | input | 2 | Register address |
| reg_wr_i | input | 1 | Write strobe |
| reg_rd_i | input | 1 | Read strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Registered read data |
| alert_n_o | output | 1 | Shared active-low alert |
| ovt_flag_o | output | 1 | Non-latching overtemperature flag |

## Verification
Single-cycle fault pulses separate latching from level following, because the bit must outlive its input. Faults held across one or more reads separate a correct conditional release from plain clear-on-read. Mask patterns test per-source masking, the group mask over register 2, and re-arming after a mask is released. Shared-bit pulses in every mode, followed by a long stretch of mixed random faults, reads and mask writes, are compared on every cycle against a behavioural model.

// File: rtl/asc_pkg.sv
package asc_pkg;
    localparam int REG_W   = 8;
    localparam int SHR_BIT = 5;

    typedef enum logic [1:0] {
        ADR_STAT1 = 2'd0,
        ADR_STAT2 = 2'd1,
        ADR_MASK1 = 2'd2,
        ADR_MASK2 = 2'd3
    } asc_addr_e;

    typedef enum logic [1:0] {
        SHR_FAN   = 2'd0,
        SHR_THERM = 2'd1,
        SHR_GPIO  = 2'd2,
        SHR_SPARE = 2'd3
    } asc_shr_e;

    typedef struct packed {
        logic [REG_W-1:0] mask1;
        logic [REG_W-1:0] mask2;
        logic [REG_W-1:0] rdata;
        logic             ovt;
    } asc_regs_t;
endpackage

// File: rtl/asc_sticky_bank.sv
module asc_sticky_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] fault_i,
    input  logic         rd_clr_i,
    output logic [W-1:0] flag_o
);
    typedef struct packed {
        logic [W-1:0] flag;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a live fault always wins over a release by read
        st_d.flag = fault_i | (rd_clr_i ? '0 : st_q.flag);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
endmodule

// File: rtl/asc_shared_src.sv
module asc_shared_src
    import asc_pkg::*;
(
    input  logic [1:0] mode_i,
    input  logic       fan_i,
    input  logic       therm_i,
    input  logic       gpio_i,
    output logic       src_o
);
    asc_shr_e mode;
    assign mode = asc_shr_e'(mode_i);

    always_comb begin
        unique case (mode)
            SHR_THERM: src_o = therm_i;
            SHR_GPIO:  src_o = gpio_i;
            default:   src_o = fan_i;
        endcase
    end
endmodule

// File: rtl/asc_alert_merge.sv
module asc_alert_merge #(
    parameter int W1 = 7,
    parameter int W2 = 8
) (
    input  logic [W1-1:0] flag1_i,
    input  logic [W2-1:0] flag2_i,
    input  logic [W1:0]   mask1_i,
    input  logic [W2-1:0] mask2_i,
    output logic          alert_req_o
);
    logic [W1-1:0] hit1;
    logic [W2-1:0] hit2;
    logic          grp2_on;

    assign hit1        = flag1_i & ~mask1_i[W1-1:0];
    assign hit2        = flag2_i & ~mask2_i;
    assign grp2_on     = ~mask1_i[W1];
    assign alert_req_o = (|hit1) | (grp2_on & (|hit2));
endmodule

// File: rtl/alert_status_ctrl.sv
module alert_status_ctrl
    import asc_pkg::*;
#(
    parameter int DW = REG_W,
    parameter int SB = SHR_BIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [DW-2:0] lim1_i,
    input  logic [DW-1:0] lim2_i,
    input  logic          ovt_i,
    input  logic          gpio_evt_i,
    input  logic [1:0]    pin_mode_i,
    input  logic [1:0]    reg_addr_i,
    input  logic          reg_wr_i,
    input  logic          reg_rd_i,
    input  logic [DW-1:0] reg_wdata_i,
    output logic [DW-1:0] reg_rdata_o,
    output logic          alert_n_o,
    output logic          ovt_flag_o
);
    localparam int N1 = DW - 1;

    asc_regs_t      st_d, st_q;
    asc_addr_e      addr;
    logic [N1-1:0]  stat1_q;
    logic [DW-1:0]  stat2_q;
    logic [DW-1:0]  src2;
    logic           shr_src;
    logic           rd_stat1, rd_stat2;
    logic [DW-1:0]  stat1_view;
    logic [DW-1:0]  mask1_q, mask2_q;
    logic           alert_req;

    assign addr     = asc_addr_e'(reg_addr_i);
    assign rd_stat1 = reg_rd_i && (addr == ADR_STAT1);
    assign rd_stat2 = reg_rd_i && (addr == ADR_STAT2);

    asc_shared_src u_shr (
        .mode_i  (pin_mode_i),
        .fan_i   (lim2_i[SB]),
        .therm_i (ovt_i),
        .gpio_i  (gpio_evt_i),
        .src_o   (shr_src)
    );

    always_comb begin
        src2     = lim2_i;
        src2[SB] = shr_src;
    end

    asc_sticky_bank #(.W(N1)) u_bank1 (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_i  (lim1_i),
        .rd_clr_i (rd_stat1),
        .flag_o   (stat1_q)
    );

    asc_sticky_bank #(.W(DW)) u_bank2 (
        .clk      (clk),
        .rst_n    (rst_n),
        .fault_i  (src2),
        .rd_clr_i (rd_stat2),
        .flag_o   (stat2_q)
    );

    assign stat1_view = {|stat2_q, stat1_q};

    always_comb begin
        st_d     = st_q;
        st_d.ovt = ovt_i;
        if (reg_rd_i) begin
            unique case (addr)
                ADR_STAT1: st_d.rdata = stat1_view;
                ADR_STAT2: st_d.rdata = stat2_q;
                ADR_MASK1: st_d.rdata = st_q.mask1;
                default:   st_d.rdata = st_q.mask2;
            endcase
        end
        if (reg_wr_i) begin
            if (addr == ADR_MASK1) st_d.mask1 = reg_wdata_i;
            if (addr == ADR_MASK2) st_d.mask2 = reg_wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mask1_q = st_q.mask1;
    assign mask2_q = st_q.mask2;

    asc_alert_merge #(.W1(N1), .W2(DW)) u_merge (
        .flag1_i     (stat1_q),
        .flag2_i     (stat2_q),
        .mask1_i     (mask1_q),
        .mask2_i     (mask2_q),
        .alert_req_o (alert_req)
    );

    assign alert_n_o   = ~alert_req;
    assign reg_rdata_o = st_q.rdata;
    assign ovt_flag_o  = st_q.ovt;
endmodule

// File: rtl/asc_checker.sv
module asc_checker #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [DW-2:0] lim1_i,
    input logic          ovt_i,
    input logic [1:0]    reg_addr_i,
    input logic          reg_wr_i,
    input logic          reg_rd_i,
    input logic [DW-1:0] reg_rdata_o,
    input logic          alert_n_o,
    input logic          ovt_flag_o,
    input logic [DW-2:0] stat1_q,
    input logic [DW-1:0] stat2_q,
    input logic [DW-1:0] mask1_q,
    input logic [DW-1:0] mask2_q
);
    AST_SET_ON_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (|lim1_i) |=> ((stat1_q & $past(lim1_i)) == $past(lim1_i))); // R2

    AST_CLEAR_NEEDS_READ1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|($past(stat1_q) & ~stat1_q)))
        |-> ($past(reg_rd_i) && ($past(reg_addr_i) == 2'd0))); // R3

    AST_CLEAR_NEEDS_READ2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (|($past(stat2_q) & ~stat2_q)))
        |-> ($past(reg_rd_i) && ($past(reg_addr_i) == 2'd1))); // R3

    AST_SUMMARY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(reg_rd_i) && ($past(reg_addr_i) == 2'd0))
        |-> (reg_rdata_o[DW-1] == (|$past(stat2_q)))); // R4

    AST_IDLE_NO_ALERT: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat1_q == '0) && (stat2_q == '0)) |-> alert_n_o); // R5

    AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(reg_wr_i)) |-> ($stable(mask1_q) && $stable(mask2_q))); // R7

    AST_OVT_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (ovt_flag_o == $past(ovt_i))); // R8
endmodule

bind alert_status_ctrl asc_checker #(.DW(DW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .lim1_i      (lim1_i),
    .ovt_i       (ovt_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wr_i    (reg_wr_i),
    .reg_rd_i    (reg_rd_i),
    .reg_rdata_o (reg_rdata_o),
    .alert_n_o   (alert_n_o),
    .ovt_flag_o  (ovt_flag_o),
    .stat1_q     (stat1_q),
    .stat2_q     (stat2_q),
    .mask1_q     (mask1_q),
    .mask2_q     (mask2_q)
);

// File: tb/alert_status_ctrl_bench.sv
module alert_status_ctrl_bench;
    localparam int TCLK = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [6:0] lim1 = '0;
    logic [7:0] lim2 = '0;
    logic       ovt = 1'b0;
    logic       gpio = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [1:0] addr = 2'd0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       alert_n;
    logic       ovt_flag;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 0;

    // behavioural reference state
    logic [6:0] ms1 = '0;
    logic [7:0] ms2 = '0;
    logic [7:0] mm1 = '0;
    logic [7:0] mm2 = '0;
    logic [7:0] mrd = '0;
    logic       movt = 1'b0;
    bit         live = 0;

    always #(TCLK/2) clk = ~clk;

    alert_status_ctrl u_alert_status_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .lim1_i      (lim1),
        .lim2_i      (lim2),
        .ovt_i       (ovt),
        .gpio_evt_i  (gpio),
        .pin_mode_i  (mode),
        .reg_addr_i  (addr),
        .reg_wr_i    (wr),
        .reg_rd_i    (rd),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .alert_n_o   (alert_n),
        .ovt_flag_o  (ovt_flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic model_alert_n();
        bit any = 0;
        for (int i = 0; i < 7; i++) if (ms1[i] && !mm1[i]) any = 1;
        if (!mm1[7])
            for (int j = 0; j < 8; j++) if (ms2[j] && !mm2[j]) any = 1;
        return !any;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            ms1 = '0; ms2 = '0; mm1 = '0; mm2 = '0; mrd = '0; movt = 1'b0;
        end else begin
            logic [7:0] src;
            src = lim2;
            if (mode == 2'd1)      src[5] = ovt;
            else if (mode == 2'd2) src[5] = gpio;
            if (rd) begin
                if (addr == 2'd0)      mrd = {ms2 != 0, ms1};
                else if (addr == 2'd1) mrd = ms2;
                else if (addr == 2'd2) mrd = mm1;
                else                   mrd = mm2;
            end
            ms1 = lim1 | ((rd && addr == 2'd0) ? 7'd0 : ms1);
            ms2 = src  | ((rd && addr == 2'd1) ? 8'd0 : ms2);
            if (wr && addr == 2'd2) mm1 = wdata;
            if (wr && addr == 2'd3) mm2 = wdata;
            movt = ovt;
        end
    end

    always @(negedge clk) begin
        if (live && !done) begin
            chk("R5 alert vs model", {7'd0, alert_n}, {7'd0, model_alert_n()});
            chk("R8 ovt flag vs model", {7'd0, ovt_flag}, {7'd0, movt});
            chk("R3 read data vs model", rdata, mrd);
        end
    end

    task automatic rd_reg(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk); addr = a; rd = 1'b1;
        @(negedge clk); rd = 1'b0;
        chk(tag, rdata, exp);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wr = 1'b1; wdata = d;
        @(negedge clk); wr = 1'b0;
    endtask

    task automatic pulse1(input logic [6:0] v);
        @(negedge clk); lim1 = v;
        @(negedge clk); lim1 = '0;
    endtask

    task automatic pulse2(input logic [7:0] v);
        @(negedge clk); lim2 = v;
        @(negedge clk); lim2 = '0;
    endtask

    task automatic chk_alert(input string tag, input logic exp);
        chk(tag, {7'd0, alert_n}, {7'd0, exp});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        live  = 1;
        @(negedge clk);
        // R1 reset state
        chk_alert("R1 alert idle", 1'b1);
        chk("R1 ovt flag", {7'd0, ovt_flag}, 8'd0);
        chk("R1 read data", rdata, 8'd0);
        for (int a = 0; a < 4; a++) rd_reg(2'(a), 8'd0, "R1 register reset");

        // R2 pulse latches, R3 released after read once gone
        pulse1(7'h10);
        chk_alert("R5 unmasked fault asserts alert", 1'b0);
        rd_reg(2'd0, 8'h10, "R2 pulse latched");
        chk_alert("R3 released after read", 1'b1);
        rd_reg(2'd0, 8'h00, "R3 cleared");

        // R3 held fault survives reads
        @(negedge clk); lim1 = 7'h01;
        rd_reg(2'd0, 8'h01, "R3 held first read");
        rd_reg(2'd0, 8'h01, "R3 held second read");
        @(negedge clk); lim1 = '0;
        rd_reg(2'd0, 8'h01, "R3 read after fault gone");
        rd_reg(2'd0, 8'h00, "R3 cleared after fault gone");

        // R4 summary bit
        pulse2(8'h80);
        rd_reg(2'd0, 8'h80, "R4 summary set");
        rd_reg(2'd1, 8'h80, "R4 status1 read kept status2");
        rd_reg(2'd0, 8'h00, "R4 summary gone");

        // R5 / R6 per-source mask
        wr_reg(2'd2, 8'h01);
        pulse1(7'h01);
        chk_alert("R5 masked source silent", 1'b1);
        rd_reg(2'd0, 8'h01, "R6 masked bit still set");
        rd_reg(2'd0, 8'h00, "R6 masked bit clears");
        wr_reg(2'd2, 8'h00);

        // R5 group mask over register 2
        wr_reg(2'd2, 8'h80);
        pulse2(8'h02);
        chk_alert("R5 group mask silent", 1'b1);
        rd_reg(2'd1, 8'h02, "R6 group masked bit set");
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd3, 8'h02);
        pulse2(8'h02);
        chk_alert("R5 mask2 bit silent", 1'b1);
        pulse2(8'h01);
        chk_alert("R5 unmasked reg2 source", 1'b0);
        rd_reg(2'd1, 8'h03, "R6 reg2 both set");
        chk_alert("R5 released", 1'b1);
        wr_reg(2'd3, 8'h00);

        // R10 re-arm after mask release
        @(negedge clk); lim1 = 7'h10;
        @(negedge clk);
        chk_alert("R10 fault alert", 1'b0);
        wr_reg(2'd2, 8'h10);
        chk_alert("R10 mask silences", 1'b1);
        @(negedge clk); lim1 = '0;
        rd_reg(2'd0, 8'h10, "R10 status read");
        wr_reg(2'd2, 8'h00);
        chk_alert("R10 no stale alert on unmask", 1'b1);
        pulse1(7'h10);
        chk_alert("R10 rearmed", 1'b0);
        rd_reg(2'd0, 8'h10, "R10 second event");
        chk_alert("R10 released", 1'b1);

        // R7 status read-only, masks read back
        wr_reg(2'd0, 8'hFF);
        wr_reg(2'd1, 8'hFF);
        rd_reg(2'd0, 8'h00, "R7 status1 write ignored");
        rd_reg(2'd1, 8'h00, "R7 status2 write ignored");
        chk_alert("R7 no alert from write", 1'b1);
        wr_reg(2'd3, 8'h5A);
        rd_reg(2'd3, 8'h5A, "R7 mask2 readback");
        wr_reg(2'd2, 8'hA5);
        rd_reg(2'd2, 8'hA5, "R7 mask1 readback");
        wr_reg(2'd2, 8'h00);
        wr_reg(2'd3, 8'h00);

        // R8 non-latching overtemperature flag
        @(negedge clk); ovt = 1'b1;
        @(negedge clk);
        chk("R8 flag follows", {7'd0, ovt_flag}, 8'd1);
        @(negedge clk); ovt = 1'b0;
        @(negedge clk);
        chk("R8 flag drops without read", {7'd0, ovt_flag}, 8'd0);
        rd_reg(2'd1, 8'h00, "R9 fan mode ignores ovt");

        // R9 shared bit source
        mode = 2'd1;
        @(negedge clk); ovt = 1'b1;
        @(negedge clk); ovt = 1'b0;
        rd_reg(2'd1, 8'h20, "R9 therm mode");
        rd_reg(2'd1, 8'h00, "R9 therm cleared");
        mode = 2'd2;
        @(negedge clk); gpio = 1'b1;
        @(negedge clk); gpio = 1'b0;
        rd_reg(2'd1, 8'h20, "R9 gpio mode");
        rd_reg(2'd1, 8'h00, "R9 gpio cleared");
        pulse2(8'h20);
        rd_reg(2'd1, 8'h00, "R9 fan ignored in gpio mode");
        mode = 2'd0;
        @(negedge clk); gpio = 1'b1;
        @(negedge clk); gpio = 1'b0;
        rd_reg(2'd1, 8'h00, "R9 gpio ignored in fan mode");
        pulse2(8'h20);
        rd_reg(2'd1, 8'h20, "R9 fan mode");
        mode = 2'd3;
        pulse2(8'h20);
        rd_reg(2'd1, 8'h20, "R9 spare mode acts as fan");
        mode = 2'd0;

        // mixed traffic, compared against the model every cycle
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            lim1  = 7'($urandom & $urandom & $urandom);
            lim2  = 8'($urandom & $urandom & $urandom);
            ovt   = 1'($urandom);
            gpio  = 1'($urandom);
            mode  = 2'($urandom);
            addr  = 2'($urandom);
            rd    = (($urandom % 3) == 0);
            wr    = (($urandom % 7) == 0);
            wdata = 8'($urandom);
        end
        @(negedge clk);
        lim1 = '0; lim2 = '0; ovt = 1'b0; gpio = 1'b0; rd = 1'b0; wr = 1'b0;
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule